// File: doc/BRIEF.md
# Decoded Bit Receive FIFO with Strobed Serial Output

This block sits behind a Manchester decoder in a sub-GHz receiver. Each decoded bit arrives with a one-cycle valid pulse. A separate tick input gives the bit-period timing reference, with sixteen ticks per bit. The block stores the accepted bits in a small one-bit-wide receive FIFO, which a host drains through a read port. It also presents the same bits on a serial data pin, together with a strobe pulse placed inside each bit period.

Bits are accepted only after an external frame-sync event. Anything before that event is discarded, including the preamble, the run-in and the sync word itself. Three configuration inputs control the FIFO:
- a clear at the start of a run cycle;
- a clear when frame sync is found;
- a lock on end of message, which freezes both the FIFO and the serial output until the next clear or reset.

A select input routes the serial data to one of two pins.

Top module: `rx_bit_stream_fifo`

## Requirements
- R1: While `rst_n` is low at a clock edge (synchronous reset), the block returns to its idle state after that edge: FIFO empty, count 0, overflow clear, lock released, frame window closed, both data pins low and strobe low.
- R2: A bit is accepted only when `bit_vld` is high and the frame window is open. The window opens on the edge after a `sync_hit` pulse and closes on the edge after a `cycle_start` pulse (`sync_hit` wins when both arrive together). Bits outside the window reach neither the FIFO nor the pins.
- R3: An accepted bit is pushed into the FIFO and shown on the selected data pin after the same clock edge. It stays on the pin until the next accepted bit. The FIFO returns bits in arrival order.
- R4: After an accepted bit the phase counter restarts at 0. Each `phase_tick` advances it, saturating at 15. `strobe` is high exactly while the phase is 1, so it rises one tick after the bit and lasts one tick.
- R5: With `cfg_lock_eom`=1, an `eom_hit` pulse sets the lock on the next edge. While locked, no bit is accepted, the FIFO count does not rise, the data pins hold their value and `strobe` stays low.
- R6: With `cfg_lock_eom`=0, `eom_hit` has no effect, and bits keep being accepted.
- R7: With `cfg_init_cycle`=1, a `cycle_start` pulse empties the FIFO, clears overflow, releases the lock and cancels any pending strobe. A bit arriving in that cycle is dropped.
- R8: With `cfg_init_frame`=1, a `sync_hit` pulse clears the FIFO in the same way as R7. With `cfg_init_frame`=0, `sync_hit` leaves the FIFO contents untouched.
- R9: `cfg_pin_sel`=0 puts the data on `pin_a`, and `cfg_pin_sel`=1 puts it on `pin_b`. The unselected pin is driven low. `strobe` always has its own pin.
- R10: `fifo_full` is high at 32 entries and `fifo_empty` is high at 0 entries. An accepted bit that arrives while the FIFO is full (checked before any read in the same cycle) is dropped from the FIFO and sets the sticky `fifo_ovf`. That bit still appears on the data pin. A clear (R7, R8) takes priority over a write or a read in the same cycle.
- R11: `rd_data` shows the oldest bit whenever the FIFO is not empty. `rd_en` removes that bit on the edge. `rd_en` on an empty FIFO has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_vld | input | 1 | One-cycle pulse marking a decoded bit |
| bit_val | input | 1 | Value of the decoded bit |
| phase_tick | input | 1 | Sixteenth-of-bit timing tick |
| cycle_start | input | 1 | Start of a run cycle (slave run start or wake-up found) |
| sync_hit | input | 1 | Frame synchronisation found |
| eom_hit | input | 1 | End of message reached |
| cfg_init_cycle | input | 1 | Clear the FIFO on cycle_start |
| cfg_init_frame | input | 1 | Clear the FIFO on sync_hit |
| cfg_lock_eom | input | 1 | Lock the FIFO and serial output on eom_hit |
| cfg_pin_sel | input | 1 | 0: data on pin_a, 1: data on pin_b |
| rd_en | input | 1 | Pop the oldest FIFO bit |
| rd_data | output | 1 | Oldest FIFO bit |
| fifo_cnt | output | 6 | Number of stored bits |
| fifo_empty | output | 1 | FIFO holds no bits |
| fifo_full | output | 1 | FIFO holds 32 bits |
| fifo_ovf | output | 1 | Sticky: a bit was dropped on a full FIFO |
| pin_a | output | 1 | Serial data pin, first choice |
| pin_b | output | 1 | Serial data pin, second choice |
| strobe | output | 1 | Active-high data strobe |

## Verification
A stuck frame window or lock shows on the next clock edge. The FIFO count then fails to rise on an accepted bit, or rises when it should not. The data pins also keep a value that should have changed. A phase counter that is off by one moves the strobe one tick early or late, which is visible within one tick of the bit. A corrupted write or read pointer changes `rd_data` at the next read, so a reference queue in the bench catches it as soon as the host drains the FIFO.

// File: rtl/rxfs_pkg.sv
package rxfs_pkg;
   // Control decisions shared by the frame controller and the datapath
   typedef struct packed {
      logic clr;       // FIFO initialisation request this cycle
      logic accept;    // decoded bit is taken this cycle
      logic locked;    // end-of-message lock held
      logic in_frame;  // frame window open
   } rxfs_ctl_t;

   typedef enum logic {
      PIN_SEL_A = 1'b0,
      PIN_SEL_B = 1'b1
   } rxfs_pin_e;

   localparam int unsigned RXFS_NUM_PINS = 2;
endpackage

// File: rtl/rxfs_frame_ctrl.sv
module rxfs_frame_ctrl
   import rxfs_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      bit_vld,
   input  logic      cycle_start,
   input  logic      sync_hit,
   input  logic      eom_hit,
   input  logic      cfg_init_cycle,
   input  logic      cfg_init_frame,
   input  logic      cfg_lock_eom,
   output rxfs_ctl_t ctl
);
   logic frame_q;
   logic lock_q;
   logic clr_req;

   assign clr_req = (cycle_start & cfg_init_cycle) | (sync_hit & cfg_init_frame);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         frame_q <= 1'b0;
      end else if (sync_hit) begin
         frame_q <= 1'b1;
      end else if (cycle_start) begin
         frame_q <= 1'b0;
      end
   end

   // The lock is set by end of message; a clear releases it
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lock_q <= 1'b0;
      end else if (eom_hit && cfg_lock_eom) begin
         lock_q <= 1'b1;
      end else if (clr_req) begin
         lock_q <= 1'b0;
      end
   end

   always_comb begin
      ctl.clr      = clr_req;
      ctl.locked   = lock_q;
      ctl.in_frame = frame_q;
      ctl.accept   = bit_vld & frame_q & ~lock_q & ~clr_req;
   end
endmodule

// File: rtl/rxfs_bit_fifo.sv
module rxfs_bit_fifo #(
   parameter int unsigned DEPTH = 32,
   localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          wr_en,
   input  logic          wr_bit,
   input  logic          rd_en,
   output logic          rd_bit,
   output logic [CW-1:0] cnt,
   output logic          full,
   output logic          empty,
   output logic          ovf
);
   logic [DEPTH-1:0] mem_q;
   logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
   logic [AW-1:0]    wr_ptr_nx, rd_ptr_nx;
   logic [CW-1:0]    cnt_q;
   logic             wr_ok, rd_ok;

   assign full  = (cnt_q == CW'(DEPTH));
   assign empty = (cnt_q == '0);
   assign wr_ok = wr_en & ~full & ~clr;
   assign rd_ok = rd_en & ~empty & ~clr;

   // Pointer advance: free wrap for power-of-two depth, compare otherwise
   generate
      if ((1 << AW) == DEPTH) begin : g_pow2_wrap
         assign wr_ptr_nx = wr_ptr_q + AW'(1);
         assign rd_ptr_nx = rd_ptr_q + AW'(1);
      end else begin : g_cmp_wrap
         assign wr_ptr_nx = (wr_ptr_q == AW'(DEPTH - 1)) ? '0 : wr_ptr_q + AW'(1);
         assign rd_ptr_nx = (rd_ptr_q == AW'(DEPTH - 1)) ? '0 : rd_ptr_q + AW'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         cnt_q    <= '0;
      end else begin
         if (wr_ok) wr_ptr_q <= wr_ptr_nx;
         if (rd_ok) rd_ptr_q <= rd_ptr_nx;
         case ({wr_ok, rd_ok})
            2'b10:   cnt_q <= cnt_q + CW'(1);
            2'b01:   cnt_q <= cnt_q - CW'(1);
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         ovf <= 1'b0;
      end else if (wr_en && full) begin
         ovf <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem_q <= '0;
      end else if (wr_ok) begin
         mem_q[wr_ptr_q] <= wr_bit;
      end
   end

   assign rd_bit = mem_q[rd_ptr_q];
   assign cnt    = cnt_q;
endmodule

// File: rtl/rxfs_strobe_gen.sv
module rxfs_strobe_gen
   import rxfs_pkg::*;
#(
   parameter int unsigned PHASES       = 16,
   parameter int unsigned STROBE_PHASE = 1,
   localparam int unsigned PW = $clog2(PHASES)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  rxfs_ctl_t                ctl,
   input  logic                     bit_val,
   input  logic                     phase_tick,
   input  logic                     pin_sel,
   output logic [RXFS_NUM_PINS-1:0] pins,
   output logic                     strobe
);
   logic [PW-1:0] phase_q;
   logic          ser_q;
   logic          arm_q;

   // Phase counter restarts on every accepted bit and saturates at the top
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PW'(PHASES - 1);
      end else if (ctl.accept) begin
         phase_q <= '0;
      end else if (phase_tick && (phase_q != PW'(PHASES - 1))) begin
         phase_q <= phase_q + PW'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ser_q <= 1'b0;
         arm_q <= 1'b0;
      end else if (ctl.accept) begin
         ser_q <= bit_val;
         arm_q <= 1'b1;
      end else if (ctl.clr) begin
         arm_q <= 1'b0;
      end
   end

   assign strobe = arm_q & ~ctl.locked & (phase_q == PW'(STROBE_PHASE));

   generate
      for (genvar p = 0; p < RXFS_NUM_PINS; p++) begin : g_pin
         assign pins[p] = ser_q & (pin_sel == 1'(p));
      end
   endgenerate
endmodule

// File: rtl/rx_bit_stream_fifo.sv
module rx_bit_stream_fifo
   import rxfs_pkg::*;
#(
   parameter int unsigned DEPTH        = 32,
   parameter int unsigned PHASES       = 16,
   parameter int unsigned STROBE_PHASE = 1,
   localparam int unsigned CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bit_vld,
   input  logic          bit_val,
   input  logic          phase_tick,
   input  logic          cycle_start,
   input  logic          sync_hit,
   input  logic          eom_hit,
   input  logic          cfg_init_cycle,
   input  logic          cfg_init_frame,
   input  logic          cfg_lock_eom,
   input  logic          cfg_pin_sel,
   input  logic          rd_en,
   output logic          rd_data,
   output logic [CW-1:0] fifo_cnt,
   output logic          fifo_empty,
   output logic          fifo_full,
   output logic          fifo_ovf,
   output logic          pin_a,
   output logic          pin_b,
   output logic          strobe
);
   generate
      if (DEPTH < 2 || PHASES < 4 || STROBE_PHASE < 1 || STROBE_PHASE >= PHASES) begin : g_bad_cfg
         initial $error("rx_bit_stream_fifo: illegal DEPTH/PHASES/STROBE_PHASE");
      end
   endgenerate

   rxfs_ctl_t                ctl;
   logic [RXFS_NUM_PINS-1:0] pins;
   logic                     frame_open;
   logic                     lock_q;

   rxfs_frame_ctrl u_ctrl (
      .clk            (clk),
      .rst_n          (rst_n),
      .bit_vld        (bit_vld),
      .cycle_start    (cycle_start),
      .sync_hit       (sync_hit),
      .eom_hit        (eom_hit),
      .cfg_init_cycle (cfg_init_cycle),
      .cfg_init_frame (cfg_init_frame),
      .cfg_lock_eom   (cfg_lock_eom),
      .ctl            (ctl)
   );

   rxfs_bit_fifo #(.DEPTH(DEPTH)) u_fifo (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (ctl.clr),
      .wr_en  (ctl.accept),
      .wr_bit (bit_val),
      .rd_en  (rd_en),
      .rd_bit (rd_data),
      .cnt    (fifo_cnt),
      .full   (fifo_full),
      .empty  (fifo_empty),
      .ovf    (fifo_ovf)
   );

   rxfs_strobe_gen #(.PHASES(PHASES), .STROBE_PHASE(STROBE_PHASE)) u_strb (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctl        (ctl),
      .bit_val    (bit_val),
      .phase_tick (phase_tick),
      .pin_sel    (cfg_pin_sel),
      .pins       (pins),
      .strobe     (strobe)
   );

   assign pin_a      = pins[PIN_SEL_A];
   assign pin_b      = pins[PIN_SEL_B];
   assign frame_open = ctl.in_frame;
   assign lock_q     = ctl.locked;
endmodule

// File: rtl/rxfs_chk.sv
module rxfs_chk #(
   parameter int unsigned CW = 6
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cfg_pin_sel,
   input logic          frame_open,
   input logic          lock_q,
   input logic [CW-1:0] fifo_cnt,
   input logic          fifo_empty,
   input logic          fifo_full,
   input logic          fifo_ovf,
   input logic          pin_a,
   input logic          pin_b,
   input logic          strobe
);
   // R1
   reset_state_chk: assert property (@(posedge clk)
      !rst_n |=> (fifo_empty && !fifo_ovf && !strobe && !pin_a && !pin_b));

   // R2
   no_prefame_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_open |=> (fifo_cnt <= $past(fifo_cnt)));

   // R5
   lock_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> (fifo_cnt <= $past(fifo_cnt)));

   // R5
   lock_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |-> !strobe);

   // R9
   pin_a_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_pin_sel |-> !pin_a);

   // R9
   pin_b_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_pin_sel |-> !pin_b);

   // R10
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fifo_ovf) |-> $past(fifo_full));

   // R10
   full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(fifo_full && fifo_empty));
endmodule

bind rx_bit_stream_fifo rxfs_chk #(.CW(CW)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_pin_sel (cfg_pin_sel),
   .frame_open  (frame_open),
   .lock_q      (lock_q),
   .fifo_cnt    (fifo_cnt),
   .fifo_empty  (fifo_empty),
   .fifo_full   (fifo_full),
   .fifo_ovf    (fifo_ovf),
   .pin_a       (pin_a),
   .pin_b       (pin_b),
   .strobe      (strobe)
);

// File: tb/rx_bit_stream_fifo_tb.sv
module rx_bit_stream_fifo_tb_top;
   localparam int DEPTH = 32;

   logic clk = 1'b0;
   logic rst_n, bit_vld, bit_val, phase_tick, cycle_start, sync_hit, eom_hit;
   logic cfg_init_cycle, cfg_init_frame, cfg_lock_eom, cfg_pin_sel, rd_en;
   logic       rd_data, fifo_empty, fifo_full, fifo_ovf, pin_a, pin_b, strobe;
   logic [5:0] fifo_cnt;

   always #4 clk = ~clk;

   rx_bit_stream_fifo dut_i (.*);

   int checks = 0;
   int fails  = 0;

   // reference model state
   bit m_q[$];
   bit m_frame, m_lock, m_ovf, m_ser, m_arm;
   int m_phase;

   function automatic bit exp_strobe();
      return m_arm && (m_phase == 1) && !m_lock;
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_edge();
      bit clr, acc, was_full;
      if (!rst_n) begin
         m_q.delete(); m_frame = 0; m_lock = 0; m_ovf = 0; m_ser = 0; m_arm = 0; m_phase = 15;
         return;
      end
      clr      = (cycle_start && cfg_init_cycle) || (sync_hit && cfg_init_frame);
      acc      = bit_vld && m_frame && !m_lock && !clr;
      was_full = (m_q.size() == DEPTH);
      if (rd_en && m_q.size() > 0 && !clr) void'(m_q.pop_front());
      if (acc) begin
         if (!was_full) m_q.push_back(bit_val);
         else m_ovf = 1;
      end
      if (clr) begin m_q.delete(); m_ovf = 0; m_arm = 0; end
      if (eom_hit && cfg_lock_eom) m_lock = 1;
      else if (clr) m_lock = 0;
      if (sync_hit) m_frame = 1;
      else if (cycle_start) m_frame = 0;
      if (acc) begin m_ser = bit_val; m_arm = 1; m_phase = 0; end
      else if (phase_tick && m_phase < 15) m_phase++;
   endtask

   task automatic compare();
      chk(fifo_cnt == m_q.size(), "R10 count", fifo_cnt, m_q.size());
      chk(fifo_empty == (m_q.size() == 0), "R10 empty", fifo_empty, m_q.size() == 0);
      chk(fifo_full == (m_q.size() == DEPTH), "R10 full", fifo_full, m_q.size() == DEPTH);
      chk(fifo_ovf == m_ovf, "R10 ovf", fifo_ovf, m_ovf);
      if (m_q.size() > 0) chk(rd_data == m_q[0], "R11 rd_data", rd_data, m_q[0]);
      chk(pin_a == (m_ser && !cfg_pin_sel), "R9 pin_a", pin_a, m_ser && !cfg_pin_sel);
      chk(pin_b == (m_ser && cfg_pin_sel), "R9 pin_b", pin_b, m_ser && cfg_pin_sel);
      chk(strobe == exp_strobe(), "R4 strobe", strobe, exp_strobe());
   endtask

   task automatic clear_pulses();
      bit_vld = 0; phase_tick = 0; cycle_start = 0; sync_hit = 0; eom_hit = 0; rd_en = 0;
   endtask

   // one clock: inputs already driven; model and compare after the edge
   task automatic cyc();
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare();
      clear_pulses();
   endtask

   task automatic send_bit(input bit v);
      bit_vld = 1; bit_val = v; cyc();
   endtask

   task automatic tick(); phase_tick = 1; cyc(); endtask

   initial begin
      int s;
      s = $urandom(32'h5eed_1234);
      rst_n = 0; bit_val = 0; clear_pulses();
      cfg_init_cycle = 0; cfg_init_frame = 0; cfg_lock_eom = 0; cfg_pin_sel = 0;
      @(negedge clk);
      cyc(); cyc();
      // R1 reset state
      chk(fifo_empty && !fifo_ovf && !pin_a && !pin_b && !strobe && fifo_cnt == 0,
          "R1 reset idle", {fifo_empty, fifo_ovf, pin_a, pin_b, strobe}, 5'b10000);
      rst_n = 1; cyc();

      // R2: bits before frame sync are dropped
      for (int i = 0; i < 5; i++) send_bit(1'b1);
      chk(fifo_cnt == 0 && !pin_a, "R2 pre-sync dropped", fifo_cnt, 0);
      sync_hit = 1; bit_vld = 1; bit_val = 1; cyc();
      chk(fifo_cnt == 0, "R2 bit in sync cycle dropped", fifo_cnt, 0);

      // R3/R4: bit on pin and strobe one tick later, one tick wide
      send_bit(1'b1);
      chk(pin_a == 1 && fifo_cnt == 1, "R3 bit presented", pin_a, 1);
      chk(strobe == 0, "R4 strobe low at phase 0", strobe, 0);
      tick();
      chk(strobe == 1, "R4 strobe high at phase 1", strobe, 1);
      cyc();
      chk(strobe == 1, "R4 strobe holds without tick", strobe, 1);
      tick();
      chk(strobe == 0, "R4 strobe low at phase 2", strobe, 0);
      send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
      chk(fifo_cnt == 4, "R3 four bits stored", fifo_cnt, 4);
      // R3 order: 1,0,1,1
      chk(rd_data == 1, "R3 order 0", rd_data, 1); rd_en = 1; cyc();
      chk(rd_data == 0, "R3 order 1", rd_data, 0); rd_en = 1; cyc();
      chk(rd_data == 1, "R3 order 2", rd_data, 1); rd_en = 1; cyc();
      rd_en = 1; cyc();
      rd_en = 1; cyc();
      chk(fifo_empty && fifo_cnt == 0, "R11 read on empty ignored", fifo_cnt, 0);

      // R6: eom without lock option has no effect
      eom_hit = 1; cyc();
      send_bit(1'b1);
      chk(fifo_cnt == 1, "R6 eom ignored", fifo_cnt, 1);

      // R5: lock freezes FIFO and pins
      cfg_lock_eom = 1; eom_hit = 1; cyc();
      send_bit(1'b0); tick(); send_bit(1'b0);
      chk(fifo_cnt == 1 && pin_a == 1 && !strobe, "R5 locked frozen", fifo_cnt, 1);

      // R9: pin select while held value is 1
      cfg_pin_sel = 1; cyc();
      chk(pin_b == 1 && pin_a == 0, "R9 routed to pin_b", pin_b, 1);
      cfg_pin_sel = 0; cyc();

      // R7: init at cycle start clears and unlocks
      cfg_init_cycle = 1; cycle_start = 1; cyc();
      chk(fifo_cnt == 0, "R7 cleared at cycle start", fifo_cnt, 0);
      sync_hit = 1; cyc();
      send_bit(1'b1);
      chk(fifo_cnt == 1, "R7 lock released", fifo_cnt, 1);
      cfg_lock_eom = 0;

      // R8: sync without frame init keeps contents, with it clears
      sync_hit = 1; cyc();
      chk(fifo_cnt == 1, "R8 kept without init", fifo_cnt, 1);
      cfg_init_frame = 1; sync_hit = 1; cyc();
      chk(fifo_cnt == 0, "R8 cleared at frame start", fifo_cnt, 0);
      cfg_init_frame = 0;

      // R10: fill past full
      for (int i = 0; i < DEPTH + 2; i++) send_bit(i[0]);
      chk(fifo_full && fifo_ovf && fifo_cnt == DEPTH, "R10 overflow", fifo_cnt, DEPTH);
      chk(pin_a == 1, "R10 dropped bit still on pin", pin_a, 1);
      rd_en = 1; cyc();
      chk(fifo_ovf, "R10 ovf sticky", fifo_ovf, 1);

      // constrained random phase
      for (int n = 0; n < 6000; n++) begin
         if (n % 250 == 0) begin
            cfg_init_cycle = 1'($urandom_range(0, 1));
            cfg_init_frame = 1'($urandom_range(0, 3) == 0);
            cfg_lock_eom   = 1'($urandom_range(0, 1));
            cfg_pin_sel    = 1'($urandom_range(0, 1));
         end
         bit_vld     = ($urandom_range(0, 99) < 35);
         bit_val     = 1'($urandom_range(0, 1));
         phase_tick  = ($urandom_range(0, 99) < 50);
         sync_hit    = ($urandom_range(0, 99) < 3);
         cycle_start = ($urandom_range(0, 199) < 2);
         eom_hit     = ($urandom_range(0, 99) < 2);
         rd_en       = ($urandom_range(0, 99) < 25);
         if (n == 3000) rst_n = 0;
         cyc();
         rst_n = 1;
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule